// File: doc/BRIEF.md
# Frequency lock detector with hysteresis

This block tells whether a fast local oscillator is running at the right multiple of a slower reference clock. It counts oscillator cycles during a window of a fixed number of reference cycles, then compares the captured count with the count an exact oscillator would produce. The ideal count is the oscillator-to-reference ratio (32 by default) times the window length. The single output flag rises when the count error is inside a narrow band, 300 ppm by default. It falls only when the error leaves a wide band, 1000 ppm by default. Between the two bands the flag keeps its last value, so a loop that wanders near the edge does not make the flag chatter.

Measuring windows alternate with gaps of equal length. During a gap the count crosses from the oscillator domain to the reference domain through a toggle request and acknowledge pair, and the oscillator side holds the value steady until it is acknowledged. A stopped oscillator never answers. The reference side notices that the answer is missing when the next window closes, and it treats that as a zero count. The flag is a register in the reference domain. It changes only just after a window closes. The block has no streaming data path: all pins are plain clocks, a reset and a level output.

Top module: `freq_lock_detect`

## Requirements
- R1: While `rst` is high at a rising edge of `ref_clk`, `lock` is low at the next edge, and it is low on the first cycle after reset is released.
- R2: The first result after reset only arms the detector and never raises `lock`, even when the oscillator is exact.
- R3: When a measured count differs from the ideal count `RATIO * 2**WIN_LOG2` by at most `floor(ideal * LOCK_PPM / 1e6)` counts, in either direction, `lock` goes high.
- R4: When the absolute error is above the narrow band but not above the wide band, `lock` keeps its previous value, whether that value is high or low.
- R5: When the absolute error exceeds `floor(ideal * UNLOCK_PPM / 1e6)` counts, `lock` goes low. This holds for a slow or a fast oscillator, including one far too fast, because the counter saturates instead of wrapping.
- R6: If the oscillator stops, the missing count is treated as zero and `lock` goes low when the following window closes. When the oscillator restarts at the right rate, `lock` returns high.
- R7: `lock` changes only in a short span after a window closes. Counting reference cycles from reset release as 1, 2, ..., a change is seen at cycle c with `c mod 2N` between N and N+20, where N = `2**WIN_LOG2`.
- R8: Windows are N reference cycles long and alternate with gaps of N cycles. The first window opens at reset release. Each window's count is held stable in the oscillator domain until the reference domain acknowledges it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; window timing and the flag live here |
| osc_clk | input | 1 | Oscillator clock under measurement |
| rst | input | 1 | Active-high reset, synchronous to `ref_clk`; retimed internally for the oscillator side |
| lock | output | 1 | High when the oscillator is frequency locked to the reference |

## Verification
The assertions assume three things. Both clocks run freely, with the oscillator many times faster than the reference, so that a two-flop retimer settles well inside one reference cycle. Reset is held long enough for its retimed copy to reach the oscillator side. The oscillator either runs or stops outright, with no runt pulses. The stimulus keeps a 250 MHz reference and moves the oscillator only by whole-period changes near the 32x rate, apart from deliberate stops and large offsets. Each frequency is held for three window-plus-gap periods before the flag is checked, so the intermediate counts from a mixed window never decide the outcome. The chosen offsets sit several counts away from either band edge, which covers the ±1 count uncertainty of the synchronizers.

// File: rtl/flk_pkg.sv
package flk_pkg;

  // Number of counts that correspond to a ppm offset on an ideal count.
  function automatic int unsigned band_counts(input int unsigned ideal,
                                              input int unsigned ppm);
    longint unsigned prod;
    prod = longint'(ideal) * longint'(ppm);
    return int'(prod / 64'd1_000_000);
  endfunction

  // Classification of one measured count against the two bands.
  typedef enum logic [1:0] {
    CLS_NEAR = 2'd0,
    CLS_MID  = 2'd1,
    CLS_FAR  = 2'd2
  } err_cls_e;

endpackage

// File: rtl/flk_sync.sv
module flk_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/flk_ref_window.sv
module flk_ref_window #(
  parameter int WIN_LOG2 = 16
) (
  input  logic clk,
  input  logic rst,
  output logic meas_lvl,
  output logic win_close
);
  logic [WIN_LOG2-1:0] ph_q;
  logic                lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= '0;
      lvl_q <= 1'b1;
    end else begin
      ph_q <= ph_q + 1'b1;
      if (&ph_q) lvl_q <= ~lvl_q;
    end
  end

  assign meas_lvl  = lvl_q;
  assign win_close = lvl_q & (&ph_q);

  // R8: the window level only flips when the phase counter restarts
  a_r8_level_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (lvl_q != $past(lvl_q)) |-> (ph_q == '0));

  // R8: closing a window always leads into a gap
  a_r8_close_to_gap: assert property (@(posedge clk) disable iff (rst)
    win_close |=> !lvl_q);
endmodule

// File: rtl/flk_osc_counter.sv
module flk_osc_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             ack_tgl,
  output logic             req_tgl,
  output logic [CNT_W-1:0] hold_cnt
);
  logic             en_d_q;
  logic [CNT_W-1:0] run_q;
  logic             fall;
  logic             busy;

  assign fall = en_d_q & ~en;
  assign busy = req_tgl ^ ack_tgl;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d_q   <= 1'b0;
      run_q    <= '0;
      hold_cnt <= '0;
      req_tgl  <= 1'b0;
    end else begin
      en_d_q <= en;
      if (fall) begin
        hold_cnt <= run_q;
        run_q    <= '0;
        req_tgl  <= ~req_tgl;
      end else if (en && !(&run_q)) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R8: a held count is never overwritten before its acknowledge returns
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(hold_cnt));

  // R5: a full counter stays full rather than wrapping to a small value
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (en && (&run_q)) |=> (&run_q));
endmodule

// File: rtl/flk_judge.sv
module flk_judge #(
  parameter int CNT_W      = 24,
  parameter int IDEAL      = 2097152,
  parameter int LOCK_CNT   = 629,
  parameter int UNLOCK_CNT = 2097
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_sync,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             win_close,
  output logic             ack_tgl,
  output logic             lock
);
  import flk_pkg::*;

  localparam logic [CNT_W-1:0] IDEAL_V  = CNT_W'(IDEAL);
  localparam logic [CNT_W-1:0] NEAR_V   = CNT_W'(LOCK_CNT);
  localparam logic [CNT_W-1:0] FAR_V    = CNT_W'(UNLOCK_CNT);

  logic             req_d_q;
  logic             primed_q;
  logic             await_q;
  logic             res_vld;
  logic             tmo;
  logic [CNT_W-1:0] err;
  err_cls_e         cls;

  assign res_vld = req_sync ^ req_d_q;
  assign tmo     = win_close & await_q;
  assign ack_tgl = req_d_q;

  always_comb begin
    err = (cnt_in >= IDEAL_V) ? (cnt_in - IDEAL_V) : (IDEAL_V - cnt_in);
    if (cnt_in == '0 || err > FAR_V) cls = CLS_FAR;
    else if (err <= NEAR_V)          cls = CLS_NEAR;
    else                             cls = CLS_MID;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d_q  <= 1'b0;
      primed_q <= 1'b0;
      await_q  <= 1'b0;
      lock     <= 1'b0;
    end else begin
      req_d_q <= req_sync;
      if (win_close)    await_q <= 1'b1;
      else if (res_vld) await_q <= 1'b0;
      if (res_vld || tmo) begin
        primed_q <= 1'b1;
        if (primed_q) begin
          if (tmo || cls == CLS_FAR) lock <= 1'b0;
          else if (cls == CLS_NEAR)  lock <= 1'b1;
        end
      end
    end
  end

  // R1: reset forces the flag low
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> !lock);

  // R2: the arming result never raises the flag
  a_r2_first_discard: assert property (@(posedge clk) disable iff (rst)
    ((res_vld || tmo) && !primed_q) |=> !lock);

  // R5: a far count always leaves the flag low
  a_r5_far_clears: assert property (@(posedge clk) disable iff (rst)
    (res_vld && !tmo && cls == CLS_FAR) |=> !lock);

  // R6: a missing result always leaves the flag low
  a_r6_timeout_clears: assert property (@(posedge clk) disable iff (rst)
    tmo |=> !lock);

  // R7: without a result or timeout the flag holds
  a_r7_change_at_event: assert property (@(posedge clk) disable iff (rst)
    !(res_vld || tmo) |=> $stable(lock));
endmodule

// File: rtl/freq_lock_detect.sv
module freq_lock_detect #(
  parameter int WIN_LOG2   = 16,
  parameter int RATIO      = 32,
  parameter int LOCK_PPM   = 300,
  parameter int UNLOCK_PPM = 1000
) (
  input  logic ref_clk,
  input  logic osc_clk,
  input  logic rst,
  output logic lock
);
  localparam int IDEAL      = RATIO << WIN_LOG2;
  localparam int CNT_W      = $clog2(IDEAL) + 2;
  localparam int LOCK_CNT   = int'(flk_pkg::band_counts(IDEAL, LOCK_PPM));
  localparam int UNLOCK_CNT = int'(flk_pkg::band_counts(IDEAL, UNLOCK_PPM));

  logic             meas_lvl;
  logic             win_close;
  logic             osc_rst;
  logic             en_osc;
  logic             req_tgl;
  logic             req_ref;
  logic             ack_tgl;
  logic             ack_osc;
  logic [CNT_W-1:0] hold_cnt;

  flk_ref_window #(.WIN_LOG2(WIN_LOG2)) u_win (
    .clk(ref_clk), .rst(rst), .meas_lvl(meas_lvl), .win_close(win_close)
  );

  flk_sync #(.W(1)) u_rst_sync (
    .clk(osc_clk), .rst(1'b0), .d(rst), .q(osc_rst)
  );

  flk_sync #(.W(1)) u_en_sync (
    .clk(osc_clk), .rst(osc_rst), .d(meas_lvl), .q(en_osc)
  );

  flk_osc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(osc_clk), .rst(osc_rst), .en(en_osc), .ack_tgl(ack_osc),
    .req_tgl(req_tgl), .hold_cnt(hold_cnt)
  );

  flk_sync #(.W(1)) u_req_sync (
    .clk(ref_clk), .rst(rst), .d(req_tgl), .q(req_ref)
  );

  flk_sync #(.W(1)) u_ack_sync (
    .clk(osc_clk), .rst(osc_rst), .d(ack_tgl), .q(ack_osc)
  );

  flk_judge #(
    .CNT_W(CNT_W), .IDEAL(IDEAL), .LOCK_CNT(LOCK_CNT), .UNLOCK_CNT(UNLOCK_CNT)
  ) u_judge (
    .clk(ref_clk), .rst(rst), .req_sync(req_ref), .cnt_in(hold_cnt),
    .win_close(win_close), .ack_tgl(ack_tgl), .lock(lock)
  );
endmodule

// File: tb/freq_lock_detect_tb.sv
`timescale 1ns/1fs
module freq_lock_detect_tb;
  localparam int WL    = 10;
  localparam int N     = 1 << WL;
  localparam int RAT   = 32;
  localparam int IDL   = RAT * N;
  localparam int LB    = (IDL * 300) / 1000000;
  localparam int UB    = (IDL * 1000) / 1000000;
  localparam real REF_HALF = 2.0;

  logic ref_clk = 1'b0;
  logic osc_clk = 1'b0;
  logic rst     = 1'b1;
  logic lock;

  int  total = 0;
  int  bad   = 0;
  int  cyc   = 0;
  bit  done  = 0;
  bit  osc_run = 1;
  real osc_half = REF_HALF / RAT;
  logic exp_lock = 1'b0;

  freq_lock_detect #(.WIN_LOG2(WL), .RATIO(RAT)) u_dut (
    .ref_clk(ref_clk), .osc_clk(osc_clk), .rst(rst), .lock(lock)
  );

  always #(REF_HALF) ref_clk = ~ref_clk;

  initial begin
    forever begin
      if (osc_run) begin
        #(osc_half) osc_clk = ~osc_clk;
      end else begin
        #(1.0);
      end
    end
  end

  always @(posedge ref_clk) if (!rst) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // R7: every flag change must land just after a window closes
  logic lock_prev = 1'b0;
  always @(negedge ref_clk) begin
    if (!rst && lock !== lock_prev) begin
      check(((cyc % (2*N)) >= N) && ((cyc % (2*N)) <= N + 20), "R7 change timing",
            cyc % (2*N), N);
    end
    lock_prev <= lock;
  end

  task automatic set_offset(input int d);
    osc_half = REF_HALF / RAT * real'(IDL) / real'(IDL + d);
    osc_run  = 1;
  endtask

  function automatic logic predict(input int d, input logic prev);
    int e;
    e = (d < 0) ? -d : d;
    if (e <= LB) return 1'b1;
    if (e > UB)  return 1'b0;
    return prev;
  endfunction

  task automatic segment(input int d, input string req);
    set_offset(d);
    exp_lock = predict(d, exp_lock);
    repeat (6*N) @(negedge ref_clk);
    check(lock === exp_lock, req, int'(lock), int'(exp_lock));
  endtask

  initial begin
    repeat (20) @(negedge ref_clk);
    rst = 1'b0;
    @(negedge ref_clk);
    check(lock === 1'b0, "R1 reset state", int'(lock), 0);
    while (cyc < 2*N - 1) @(negedge ref_clk);
    check(lock === 1'b0, "R2 first result discarded", int'(lock), 0);
    while (cyc < 3*N + 30) @(negedge ref_clk);
    exp_lock = 1'b1;
    check(lock === 1'b1, "R3 R8 exact rate locks", int'(lock), 1);

    segment(4,     "R3 small fast offset");
    segment(20,    "R4 hold high, fast");
    segment(45,    "R5 fast beyond wide band");
    segment(20,    "R4 hold low, fast");
    segment(-4,    "R3 small slow offset");
    segment(-20,   "R4 hold high, slow");
    segment(-45,   "R5 slow beyond wide band");
    segment(-20,   "R4 hold low, slow");
    segment(0,     "R3 relock exact");

    osc_run  = 0;
    exp_lock = 1'b0;
    repeat (6*N) @(negedge ref_clk);
    check(lock === 1'b0, "R6 stopped oscillator", int'(lock), 0);
    segment(0,     "R6 restart relocks");

    segment(3000,  "R5 far too fast");
    segment(0,     "R8 relock after saturation");
    segment(-3000, "R5 far too slow");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge ref_clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule